// File: doc/BRIEF.md
# Pushbutton Combination Lock

The lock reads a 4-bit code from slide switches each time the user presses a pushbutton. The button is active-low and mechanical, so its level is inverted, brought into the clock domain through a two-flop synchronizer and debounced. The debouncer accepts a new level only after the synchronized input has held that level for a set number of sample ticks. A free-running divider on the system clock produces those ticks. An edge detector turns each accepted press into a single one-clock entry strobe.

A small state machine counts entries and remembers whether any entry disagreed with the secret, which is a parameter. Each entry is compared with the secret nibble for its position. After the fourth entry the machine raises either the open flag or the fail flag, never earlier, so the position of a wrong digit is not revealed. The flag stays up until a reset or the next press. That press only clears the result, and the following press is again the first entry.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a clock edge, both flags go low and entry restarts at position 0, with any recorded mismatch cleared.
- R2: `btn_n` is active-low. A low pulse shorter than `STABLE_N` sample ticks of `TICK_DIV` clocks each produces no entry.
- R3: A press held for any length of time produces exactly one entry.
- R4: Entry k (k = 0..3) is compared with `SECRET[4k+3:4k]`. When all four match, `open_o` rises after the fourth entry.
- R5: A mismatch at any position raises `fail_o` only after the fourth entry. Both flags stay low until then.
- R6: `open_o` and `fail_o` are never high together.
- R7: A raised flag holds until reset or the next press. That press clears both flags and is not counted as an entry.
- R8: The internal entry strobe is never high on two consecutive clocks.
- R9: A reset in the middle of a sequence discards the partial entries, so four correct entries afterwards open the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_n | input | 1 | Raw pushbutton, low when pressed, asynchronous |
| sw | input | 4 | Code switches, asynchronous |
| open_o | output | 1 | Correct sequence entered |
| fail_o | output | 1 | Wrong sequence entered |

## Verification
A wrong position count or a lost mismatch bit stays hidden until a sequence ends. It then shows up as a flag one press too early or too late, or as the wrong flag, within a few clocks of the fourth debounced press. A debouncer that passes short glitches, or an edge detector that repeats while the button is held, shows up the same way: the extra entry shifts the count, so the result appears after only three real presses. The bench therefore checks that both flags are low after three presses, and checks which flag rises after the fourth.

// File: rtl/lock_pkg.sv
package lock_pkg;
    localparam int CODE_W = 4;
    localparam int STEPS  = 4;
    localparam int POS_W  = $clog2(STEPS);

    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        ST_ENTRY = 2'd0,
        ST_OPEN  = 2'd1,
        ST_FAIL  = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             miss;
    } entry_ctx_t;

    function automatic code_t secret_at(input logic [CODE_W*STEPS-1:0] s,
                                        input logic [POS_W-1:0] idx);
        return s[int'(idx)*CODE_W +: CODE_W];
    endfunction
endpackage

// File: rtl/lock_sync.sv
module lock_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            dout   <= '0;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/lock_debounce.sv
module lock_debounce #(
    parameter int TICK_DIV = 50000,
    parameter int STABLE_N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int TW = $clog2(TICK_DIV + 1);
    localparam int SW = $clog2(STABLE_N + 1);

    logic [TW-1:0] tick_cnt;
    logic [SW-1:0] hold_cnt;
    logic          tick;

    assign tick = (tick_cnt == TW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) tick_cnt <= '0;
        else             tick_cnt <= tick_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
            dout     <= 1'b0;
        end else if (din == dout) begin
            hold_cnt <= '0;
        end else if (tick) begin
            if (hold_cnt == SW'(STABLE_N - 1)) begin
                dout     <= din;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lock_edge.sv
module lock_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic pulse
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign pulse = level & ~prev_q;
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
    import lock_pkg::*;
#(
    parameter logic [CODE_W*STEPS-1:0] SECRET = 16'h93C5
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  stb,
    input  code_t code,
    output logic  open_o,
    output logic  fail_o
);
    lock_state_e st, st_n;
    entry_ctx_t  ctx, ctx_n;
    logic        miss_now;

    always_comb begin
        st_n     = st;
        ctx_n    = ctx;
        miss_now = ctx.miss;
        case (st)
            ST_ENTRY: begin
                if (stb) begin
                    miss_now = ctx.miss | (code != secret_at(SECRET, ctx.pos));
                    if (ctx.pos == POS_W'(STEPS - 1)) begin
                        st_n  = miss_now ? ST_FAIL : ST_OPEN;
                        ctx_n = '0;
                    end else begin
                        ctx_n.pos  = ctx.pos + 1'b1;
                        ctx_n.miss = miss_now;
                    end
                end
            end
            ST_OPEN, ST_FAIL: begin
                if (stb) begin
                    st_n  = ST_ENTRY;
                    ctx_n = '0;
                end
            end
            default: begin
                st_n  = ST_ENTRY;
                ctx_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_ENTRY;
            ctx <= '0;
        end else begin
            st  <= st_n;
            ctx <= ctx_n;
        end
    end

    assign open_o = (st == ST_OPEN);
    assign fail_o = (st == ST_FAIL);
endmodule

// File: rtl/combo_lock.sv
module combo_lock
    import lock_pkg::*;
#(
    parameter int TICK_DIV = 50000,
    parameter int STABLE_N = 4,
    parameter logic [CODE_W*STEPS-1:0] SECRET = 16'h93C5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              btn_n,
    input  logic [CODE_W-1:0] sw,
    output logic              open_o,
    output logic              fail_o
);
    logic [CODE_W:0] raw_in, sync_out;
    logic            pressed_clean;
    logic            entry_stb;

    assign raw_in = {sw, ~btn_n};

    lock_sync #(.W(CODE_W + 1)) sync_i (
        .clk(clk), .rst(rst), .din(raw_in), .dout(sync_out)
    );

    lock_debounce #(.TICK_DIV(TICK_DIV), .STABLE_N(STABLE_N)) deb_i (
        .clk(clk), .rst(rst), .din(sync_out[0]), .dout(pressed_clean)
    );

    lock_edge edge_i (
        .clk(clk), .rst(rst), .level(pressed_clean), .pulse(entry_stb)
    );

    lock_fsm #(.SECRET(SECRET)) fsm_i (
        .clk(clk), .rst(rst), .stb(entry_stb), .code(sync_out[CODE_W:1]),
        .open_o(open_o), .fail_o(fail_o)
    );
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk (
    input logic clk,
    input logic rst,
    input logic stb,
    input logic open_o,
    input logic fail_o
);
    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (!open_o && !fail_o));

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(open_o && fail_o));

    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb);

    assert_open_after_entry_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> $past(stb));

    assert_fail_after_entry_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(fail_o) |-> $past(stb));

    assert_open_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (open_o && !stb) |=> open_o);

    assert_fail_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (fail_o && !stb) |=> fail_o);
endmodule

bind combo_lock combo_lock_chk chk_i (
    .clk(clk), .rst(rst), .stb(entry_stb), .open_o(open_o), .fail_o(fail_o)
);

// File: tb/combo_lock_tb_top.sv
`timescale 1ns/1ps
module combo_lock_tb_top;
    localparam int          TICK_DIV = 4;
    localparam int          STABLE_N = 3;
    localparam logic [15:0] SECRET   = 16'h93C5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_n = 1'b1;
    logic [3:0] sw = 4'h0;
    logic       open_o, fail_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [1:0] exp_q[$];
    logic [1:0] prev_res = 2'b00;

    always #2.5 clk = ~clk;

    combo_lock #(.TICK_DIV(TICK_DIV), .STABLE_N(STABLE_N), .SECRET(SECRET)) dut_i (
        .clk(clk), .rst(rst), .btn_n(btn_n), .sw(sw), .open_o(open_o), .fail_o(fail_o)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {open,fail} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic press(input logic [3:0] v, input int hold);
        sw = v;
        repeat (5) @(negedge clk);
        btn_n = 1'b0;
        repeat (hold) @(negedge clk);
        btn_n = 1'b1;
        repeat (60) @(negedge clk);
    endtask

    function automatic logic [1:0] expect4(input logic [3:0] a, b, c, d);
        return ({d, c, b, a} == SECRET) ? 2'b10 : 2'b01;
    endfunction

    task automatic enter4(input logic [3:0] a, b, c, d);
        press(a, 40); press(b, 40); press(c, 40);
        check("R5 no result before fourth entry", {open_o, fail_o}, 2'b00);
        exp_q.push_back(expect4(a, b, c, d));
        press(d, 40);
    endtask

    task automatic clear_result();
        press(4'h0, 40);
        check("R7 press clears result", {open_o, fail_o}, 2'b00);
    endtask

    // monitor: each newly raised result is compared with the scoreboard
    always @(negedge clk) begin
        logic [1:0] cur;
        cur = {open_o, fail_o};
        if (!rst && cur != 2'b00 && prev_res == 2'b00) begin
            check("R6 flags exclusive", {1'b0, open_o && fail_o}, 2'b00);
            if (exp_q.size() == 0) check("R5 unexpected result", cur, 2'b00);
            else                   check("R4/R5 result", cur, exp_q.pop_front());
        end
        prev_res = rst ? 2'b00 : cur;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 reset state", {open_o, fail_o}, 2'b00);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        // R4: correct sequence opens; R7: result holds
        enter4(4'h5, 4'hC, 4'h3, 4'h9);
        repeat (200) @(negedge clk);
        check("R7 open holds", {open_o, fail_o}, 2'b10);

        // R5: mismatch at first position
        clear_result();
        enter4(4'h6, 4'hC, 4'h3, 4'h9);
        repeat (200) @(negedge clk);
        check("R7 fail holds", {open_o, fail_o}, 2'b01);

        // R3/R8: long holds still count once each
        clear_result();
        press(4'h5, 600); press(4'hC, 900); press(4'h3, 600);
        check("R3 long hold is one entry", {open_o, fail_o}, 2'b00);
        exp_q.push_back(2'b10);
        press(4'h9, 40);

        // R2: short glitch with wrong value is ignored
        clear_result();
        press(4'h5, 40);
        sw = 4'hF;
        repeat (5) @(negedge clk);
        btn_n = 1'b0; repeat (5) @(negedge clk); btn_n = 1'b1;
        repeat (60) @(negedge clk);
        press(4'hC, 40); press(4'h3, 40);
        check("R2 glitch ignored", {open_o, fail_o}, 2'b00);
        exp_q.push_back(2'b10);
        press(4'h9, 40);

        // R2: bouncing contact on a real press
        clear_result();
        sw = 4'h5;
        repeat (5) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            btn_n = 1'b0; repeat (2) @(negedge clk);
            btn_n = 1'b1; repeat (2) @(negedge clk);
        end
        btn_n = 1'b0; repeat (40) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            btn_n = 1'b1; repeat (2) @(negedge clk);
            btn_n = 1'b0; repeat (2) @(negedge clk);
        end
        btn_n = 1'b1; repeat (60) @(negedge clk);
        press(4'hC, 40); press(4'h3, 40);
        check("R2 bounced press counted once", {open_o, fail_o}, 2'b00);
        exp_q.push_back(2'b10);
        press(4'h9, 40);

        // R9: reset mid-sequence
        clear_result();
        press(4'h5, 40); press(4'h1, 40);
        @(negedge clk); rst = 1'b1; repeat (2) @(negedge clk);
        check("R1 reset mid-sequence", {open_o, fail_o}, 2'b00);
        rst = 1'b0; repeat (10) @(negedge clk);
        enter4(4'h5, 4'hC, 4'h3, 4'h9);
        repeat (20) @(negedge clk);
        check("R9 fresh sequence after reset", {open_o, fail_o}, 2'b10);

        // R5: mismatch at last position
        clear_result();
        enter4(4'h5, 4'hC, 4'h3, 4'h8);
        repeat (20) @(negedge clk);
        check("R5 last mismatch fails", {open_o, fail_o}, 2'b01);

        check("R4 all results seen", {1'b0, exp_q.size() != 0}, 2'b00);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule